// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block turns a queue of 32-bit command words into cycles on an 8-bit NAND flash bus. Software or a bus adapter pushes words into a small command queue. The sequencer then takes them one at a time and produces one of four cycle kinds:

- a command latch;
- an address latch;
- a burst of data writes;
- a burst of data reads.

Write data comes from a byte stream fed by a DMA engine, and read data goes back to that engine on a second byte stream. Every strobe uses fixed clock counts.

Each word carries its own control fields: the cycle kind, a byte or a byte count, a wait-for-ready flag, an end-of-operation flag and an interrupt request flag. Completion and errors appear in a write-one-to-clear status vector, and an interrupt line is the OR of that vector.

A write burst whose data stream stays empty for too long is an error. It discards the current entry, empties the queue and stops the sequencer until software clears the error bit.

Top module: `nand_cyc_seq`

## Requirements
- R1: Command word bits 17:16 select the cycle kind: 0 = address, 1 = command, 2 = data write, 3 = data read. A command entry drives bits 7:0 on the data bus with nand_cle high for exactly one WE# strobe. An address entry does the same with nand_ale high. nand_cle and nand_ale are never high together.
- R2: For a data write, bits 11:0 hold the byte count minus one. The sequencer makes that many WE# strobes. Each byte is taken from the write stream on a cycle where tx_valid and tx_ready are both high, and is driven with nand_dq_oe high.
- R3: For a data read, bits 11:0 hold the byte count minus one. The sequencer makes that many RE# strobes with nand_dq_oe low. It samples nand_dq_in on the clock edge where RE# returns high and presents that byte with a one-cycle rx_valid pulse.
- R4: Every WE# or RE# strobe is low for exactly 2 clocks and high for at least 2 clocks before the next strobe. WE# and RE# are never low together.
- R5: When bit 19 is set, the entry does not complete until nand_rdy is sampled high after its last strobe.
- R6: When bit 13 is set, completion of the entry sets int_status bit 9. When bit 13 is clear, completion leaves the status unchanged. irq is the OR of all int_status bits.
- R7: When bit 18 is set, completion of the entry gives a single-cycle pulse on op_last.
- R8: If a data write waits TIMEOUT clocks without tx_valid, int_status bit 11 is set, the entry is dropped and every queued entry is discarded.
- R9: While int_status bit 11 is set, no new entry is started and no strobe occurs.
- R10: A 1 on an int_clr bit clears that int_status bit. A set event in the same cycle takes priority over the clear.
- R11: The queue holds FIFO_DEPTH entries and runs them in push order. cmd_full is high when the queue is full, and a push while full is dropped.
- R12: After reset, WE# and RE# are high, CLE, ALE and nand_dq_oe are low, int_status is zero and cmd_full is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Push cmd_word into the command queue |
| cmd_word | input | 32 | Command word |
| cmd_full | output | 1 | Command queue full |
| tx_valid | input | 1 | Write stream byte valid |
| tx_data | input | 8 | Write stream byte |
| tx_ready | output | 1 | Sequencer accepts a write byte |
| rx_valid | output | 1 | Read byte valid (one-cycle pulse) |
| rx_data | output | 8 | Read byte |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rdy | input | 1 | Device ready (high) / busy (low) |
| int_clr | input | 16 | Write-one-to-clear mask for int_status |
| int_status | output | 16 | Status: bit 9 done, bit 11 error |
| irq | output | 1 | OR of int_status |
| op_last | output | 1 | Pulse on completion of an end-of-operation entry |

## Verification
The assertions watch the bus itself on every cycle:

- WE# and RE# are never low together, and CLE and ALE are never high together.
- Every strobe is exactly two clocks low.
- The output enable stays off during read strobes.
- A read byte only appears right after a read strobe ends.
- op_last lasts a single cycle.
- While the error bit is set, no strobe occurs.

The bench scenarios cover what depends on the command stream. They check byte counts and latch kinds per entry, that written and read byte values match the streams, and that completion is held off while the device reports busy. They also check that the error flushes the queued entries and that the sequencer resumes after the error is cleared.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int WORD_W    = 32;
    localparam int STAT_W    = 16;
    localparam int KIND_LSB  = 16;
    localparam int WFR_BIT   = 19;
    localparam int LAST_BIT  = 18;
    localparam int IWC_BIT   = 13;
    localparam int DONE_IRQ  = 9;
    localparam int ERR_IRQ   = 11;

    typedef enum logic [1:0] {
        CK_ADDR  = 2'd0,
        CK_CMD   = 2'd1,
        CK_WRITE = 2'd2,
        CK_READ  = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_TXWAIT,
        SQ_ISSUE,
        SQ_STROBE,
        SQ_RDYWAIT,
        SQ_FINISH
    } seq_state_e;

endpackage

// File: rtl/nseq_fifo.sv
module nseq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (ptr_q.cnt == FULL_CNT);
    assign empty   = (ptr_q.cnt == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign dout    = mem[ptr_q.rd];

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (push_ok) ptr_d.wr = (ptr_q.wr == LAST_IDX) ? '0 : ptr_q.wr + 1'b1;
            if (pop_ok)  ptr_d.rd = (ptr_q.rd == LAST_IDX) ? '0 : ptr_q.rd + 1'b1;
            if (push_ok && !pop_ok)      ptr_d.cnt = ptr_q.cnt + 1'b1;
            else if (pop_ok && !push_ok) ptr_d.cnt = ptr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[ptr_q.wr] <= din;
    end

endmodule

// File: rtl/nseq_strobe.sv
module nseq_strobe #(
    parameter int LOW_CLKS  = 2,
    parameter int HIGH_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic rise,
    output logic done
);
    localparam int MAXC = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] LOW_END  = CW'(LOW_CLKS - 1);
    localparam logic [CW-1:0] HIGH_END = CW'(HIGH_CLKS - 1);

    typedef enum logic [1:0] { PH_IDLE, PH_LOW, PH_HIGH } phase_e;

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } stb_t;

    stb_t s_d, s_q;

    assign active = (s_q.ph == PH_LOW);
    assign rise   = (s_q.ph == PH_LOW)  && (s_q.cnt == LOW_END);
    assign done   = (s_q.ph == PH_HIGH) && (s_q.cnt == HIGH_END);

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph  = PH_LOW;
                    s_d.cnt = '0;
                end
            end
            PH_LOW: begin
                if (s_q.cnt == LOW_END) begin
                    s_d.ph  = PH_HIGH;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (s_q.cnt == HIGH_END) begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/nand_cyc_seq.sv
module nand_cyc_seq
    import nseq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 12,
    parameter int TIMEOUT    = 64,
    parameter int STB_LOW    = 2,
    parameter int STB_HIGH   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_word,
    output logic        cmd_full,
    input  logic        tx_valid,
    input  logic [7:0]  tx_data,
    output logic        tx_ready,
    output logic        rx_valid,
    output logic [7:0]  rx_data,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rdy,
    input  logic [15:0] int_clr,
    output logic [15:0] int_status,
    output logic        irq,
    output logic        op_last
);
    localparam int TO_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [TO_W-1:0] TO_END = TO_W'(TIMEOUT - 1);

    typedef struct packed {
        seq_state_e        st;
        cyc_kind_e         kind;
        logic              wfr;
        logic              last;
        logic              iwc;
        logic [CNT_W-1:0]  rem;
        logic [TO_W-1:0]   tmo;
        logic              cle;
        logic              ale;
        logic              oe;
        logic [7:0]        dq;
        logic              rx_v;
        logic [7:0]        rx_d;
        logic              op_last;
        logic [STAT_W-1:0] stat;
    } seq_t;

    seq_t q, d;

    logic [WORD_W-1:0] head;
    logic              fifo_empty, fifo_pop, fifo_flush;
    logic              stb_start, stb_active, stb_rise, stb_done;
    logic [STAT_W-1:0] stat_set;
    logic              unused_bits;

    assign unused_bits = ^{head[31:20], head[15:14], head[12]};

    nseq_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_wr),
        .din   (cmd_word),
        .pop   (fifo_pop),
        .flush (fifo_flush),
        .dout  (head),
        .empty (fifo_empty),
        .full  (cmd_full)
    );

    nseq_strobe #(
        .LOW_CLKS  (STB_LOW),
        .HIGH_CLKS (STB_HIGH)
    ) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (stb_start),
        .active (stb_active),
        .rise   (stb_rise),
        .done   (stb_done)
    );

    always_comb begin
        d          = q;
        d.rx_v     = 1'b0;
        d.op_last  = 1'b0;
        fifo_pop   = 1'b0;
        fifo_flush = 1'b0;
        stb_start  = 1'b0;
        tx_ready   = 1'b0;
        stat_set   = '0;

        case (q.st)
            SQ_IDLE: begin
                if (!fifo_empty && !q.stat[ERR_IRQ]) begin
                    fifo_pop = 1'b1;
                    d.kind   = cyc_kind_e'(head[KIND_LSB+1:KIND_LSB]);
                    d.wfr    = head[WFR_BIT];
                    d.last   = head[LAST_BIT];
                    d.iwc    = head[IWC_BIT];
                    d.tmo    = '0;
                    d.cle    = 1'b0;
                    d.ale    = 1'b0;
                    d.rem    = head[CNT_W-1:0];
                    case (cyc_kind_e'(head[KIND_LSB+1:KIND_LSB]))
                        CK_CMD: begin
                            d.cle = 1'b1;
                            d.oe  = 1'b1;
                            d.dq  = head[7:0];
                            d.rem = '0;
                            d.st  = SQ_ISSUE;
                        end
                        CK_ADDR: begin
                            d.ale = 1'b1;
                            d.oe  = 1'b1;
                            d.dq  = head[7:0];
                            d.rem = '0;
                            d.st  = SQ_ISSUE;
                        end
                        CK_WRITE: begin
                            d.oe = 1'b1;
                            d.st = SQ_TXWAIT;
                        end
                        default: begin
                            d.oe = 1'b0;
                            d.st = SQ_ISSUE;
                        end
                    endcase
                end
            end
            SQ_TXWAIT: begin
                tx_ready = 1'b1;
                if (tx_valid) begin
                    d.dq  = tx_data;
                    d.tmo = '0;
                    d.st  = SQ_ISSUE;
                end else if (q.tmo == TO_END) begin
                    fifo_flush        = 1'b1;
                    stat_set[ERR_IRQ] = 1'b1;
                    d.oe              = 1'b0;
                    d.st              = SQ_IDLE;
                end else begin
                    d.tmo = q.tmo + 1'b1;
                end
            end
            SQ_ISSUE: begin
                stb_start = 1'b1;
                d.st      = SQ_STROBE;
            end
            SQ_STROBE: begin
                if (stb_rise && (q.kind == CK_READ)) begin
                    d.rx_v = 1'b1;
                    d.rx_d = nand_dq_in;
                end
                if (stb_done) begin
                    if (q.rem == '0) begin
                        d.st = q.wfr ? SQ_RDYWAIT : SQ_FINISH;
                    end else begin
                        d.rem = q.rem - 1'b1;
                        d.st  = (q.kind == CK_WRITE) ? SQ_TXWAIT : SQ_ISSUE;
                    end
                end
            end
            SQ_RDYWAIT: begin
                if (nand_rdy) d.st = SQ_FINISH;
            end
            SQ_FINISH: begin
                d.cle              = 1'b0;
                d.ale              = 1'b0;
                d.oe               = 1'b0;
                stat_set[DONE_IRQ] = q.iwc;
                d.op_last          = q.last;
                d.st               = SQ_IDLE;
            end
            default: d.st = SQ_IDLE;
        endcase

        d.stat = (q.stat & ~int_clr) | stat_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign nand_cle    = q.cle;
    assign nand_ale    = q.ale;
    assign nand_dq_out = q.dq;
    assign nand_dq_oe  = q.oe;
    assign nand_we_n   = ~(stb_active && (q.kind != CK_READ));
    assign nand_re_n   = ~(stb_active && (q.kind == CK_READ));
    assign rx_valid    = q.rx_v;
    assign rx_data     = q.rx_d;
    assign op_last     = q.op_last;
    assign int_status  = q.stat;
    assign irq         = |q.stat;

endmodule

// File: rtl/nand_cyc_seq_chk.sv
module nand_cyc_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_dq_oe,
    input logic        rx_valid,
    input logic        op_last,
    input logic        cmd_full,
    input logic [15:0] int_status
);

    p_latch_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_we_min_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |=> !nand_we_n);

    p_we_max_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |=> nand_we_n);

    p_re_max_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_re_n && $past(!nand_re_n)) |=> nand_re_n);

    p_read_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    p_rx_after_re_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(!nand_re_n));

    p_last_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_last |=> !op_last);

    p_err_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[11]) |-> !cmd_full);

    p_err_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int_status[11] |-> (nand_we_n && nand_re_n));

endmodule

bind nand_cyc_seq nand_cyc_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_dq_oe (nand_dq_oe),
    .rx_valid   (rx_valid),
    .op_last    (op_last),
    .cmd_full   (cmd_full),
    .int_status (int_status)
);

// File: tb/nand_cyc_seq_tb.sv
module nand_cyc_seq_tb;
    localparam int CLK_P   = 10;
    localparam int TMO     = 64;
    localparam int NVEC    = 6;

    // {word[67:36], n_we[35:28], n_re[27:20], n_cle[19:16], n_ale[15:12], n_last[11:8], byte0[7:0]}
    localparam logic [67:0] VEC [NVEC] = '{
        {32'h0001_2090, 8'd1, 8'd0, 4'd1, 4'd0, 4'd0, 8'h90},  // R1 command
        {32'h0004_205A, 8'd1, 8'd0, 4'd0, 4'd1, 4'd1, 8'h5A},  // R1 address, R7 last
        {32'h0009_2070, 8'd1, 8'd0, 4'd1, 4'd0, 4'd0, 8'h70},  // R5 wait ready
        {32'h0002_2003, 8'd4, 8'd0, 4'd0, 4'd0, 4'd0, 8'h10},  // R2 write 4
        {32'h0003_2002, 8'd0, 8'd3, 4'd0, 4'd0, 4'd0, 8'h00},  // R3 read 3
        {32'h000F_2000, 8'd0, 8'd1, 4'd0, 4'd0, 4'd1, 8'h00}   // R3 R5 R7 read 1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_full;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in;
    logic        nand_rdy;
    logic [15:0] int_clr = '0;
    logic [15:0] int_status;
    logic        irq;
    logic        op_last;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic       tx_en = 1'b1;
    logic [7:0] tx_val = 8'h10;
    logic [7:0] rd_val = 8'hA0;
    logic [7:0] exp_rx = 8'hA0;
    int busy_len = 5;
    int busy_cnt = 0;

    int we_cnt, re_cnt, cle_cnt, ale_cnt, last_cnt, rx_cnt, rx_err, tviol;
    logic [7:0] we_first, we_lastb;
    int low_run = 0, hi_run = 100;
    logic strobe_prev = 1'b0, we_prev = 1'b1, re_prev = 1'b1;

    assign tx_valid   = tx_en;
    assign tx_data    = tx_val;
    assign nand_dq_in = rd_val;
    assign nand_rdy   = (busy_cnt == 0);

    always #(CLK_P/2) clk = ~clk;

    nand_cyc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cmd_full(cmd_full), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy), .int_clr(int_clr),
        .int_status(int_status), .irq(irq), .op_last(op_last)
    );

    // stream source: advance on each accepted byte
    always @(posedge clk) begin
        if (tx_valid && tx_ready) tx_val <= tx_val + 8'd1;
    end

    // bus monitor and device model, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic strobe;
            strobe = !nand_we_n || !nand_re_n;
            if (strobe) begin
                if (!strobe_prev && hi_run < 2) tviol++;
                low_run++;
            end else begin
                if (strobe_prev) begin
                    if (low_run != 2) tviol++;
                    low_run = 0;
                    hi_run  = 0;
                end
                hi_run++;
            end
            strobe_prev = strobe;

            if (busy_cnt > 0) busy_cnt--;
            if (!we_prev && nand_we_n) begin
                if (we_cnt == 0) we_first = nand_dq_out;
                we_lastb = nand_dq_out;
                we_cnt++;
                if (nand_cle) cle_cnt++;
                if (nand_ale) ale_cnt++;
                busy_cnt = busy_len;
            end
            if (!re_prev && nand_re_n) begin
                re_cnt++;
                rd_val = rd_val + 8'd1;
            end
            we_prev = nand_we_n;
            re_prev = nand_re_n;
            if (op_last) last_cnt++;
            if (rx_valid) begin
                rx_cnt++;
                if (rx_data !== exp_rx) rx_err++;
                exp_rx = exp_rx + 8'd1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        cmd_wr   = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic clear_counts();
        we_cnt = 0; re_cnt = 0; cle_cnt = 0; ale_cnt = 0; last_cnt = 0; rx_cnt = 0;
    endtask

    task automatic clear_status(input logic [15:0] m);
        @(negedge clk);
        int_clr = m;
        @(negedge clk);
        int_clr = '0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 1000; k++) begin
            if (int_status[9]) break;
            @(negedge clk);
        end
        tick(2);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rx_err = 0; tviol = 0; we_first = '0; we_lastb = '0;
        clear_counts();
        tick(3);
        // R12 reset state
        check("R12 we_n", {31'd0, nand_we_n}, 32'd1);
        check("R12 re_n", {31'd0, nand_re_n}, 32'd1);
        check("R12 cle/ale/oe", {29'd0, nand_cle, nand_ale, nand_dq_oe}, 32'd0);
        check("R12 status", {16'd0, int_status}, 32'd0);
        check("R12 full", {31'd0, cmd_full}, 32'd0);
        rst_n = 1'b1;
        tick(2);

        for (int i = 0; i < NVEC; i++) begin
            logic [67:0] v;
            v = VEC[i];
            clear_counts();
            push(v[67:36]);
            wait_done();
            check($sformatf("R1/R2 vec%0d we strobes", i), we_cnt, {24'd0, v[35:28]});
            check($sformatf("R3 vec%0d re strobes", i), re_cnt, {24'd0, v[27:20]});
            check($sformatf("R3 vec%0d rx bytes", i), rx_cnt, {24'd0, v[27:20]});
            check($sformatf("R1 vec%0d cle strobes", i), cle_cnt, {28'd0, v[19:16]});
            check($sformatf("R1 vec%0d ale strobes", i), ale_cnt, {28'd0, v[15:12]});
            check($sformatf("R7 vec%0d last pulses", i), last_cnt, {28'd0, v[11:8]});
            if (v[35:28] != 0)
                check($sformatf("R1/R2 vec%0d first byte", i), {24'd0, we_first}, {24'd0, v[7:0]});
            check($sformatf("R6 vec%0d done irq", i), {30'd0, int_status[9], irq}, 32'd3);
            clear_status(16'h0200);
            check($sformatf("R10 vec%0d cleared", i), {16'd0, int_status}, 32'd0);
        end
        check("R2 write stream consumed", {24'd0, tx_val}, 32'h14);
        check("R2 last written byte", {24'd0, we_lastb}, 32'h13);
        check("R3 read data matches", rx_err, 0);
        check("R4 strobe timing", tviol, 0);

        // R5: completion held while device busy
        busy_len = 20;
        clear_counts();
        push(32'h0009_20E0);
        for (int k = 0; k < 200 && we_cnt == 0; k++) @(negedge clk);
        tick(8);
        check("R5 no done while busy", {31'd0, int_status[9]}, 32'd0);
        wait_done();
        check("R5 done after ready", {31'd0, int_status[9]}, 32'd1);
        clear_status(16'h0200);
        busy_len = 5;

        // R6: no interrupt request -> status untouched
        clear_counts();
        push(32'h0001_0011);
        tick(30);
        check("R6 entry ran", we_cnt, 1);
        check("R6 no status without request", {15'd0, int_status, irq}, 32'd0);

        // R8: write stalls on empty stream -> error and flush
        tx_en = 1'b0;
        clear_counts();
        push(32'h0002_2001);
        push(32'h0001_2055);
        tick(TMO + 20);
        check("R8 error flag", {30'd0, int_status[11], irq}, 32'd3);
        check("R8 no strobes", we_cnt, 0);
        tx_en = 1'b1;

        // R9/R11: halted while error set; queue fills and drops extra push
        push(32'h0001_20AA);
        push(32'h0001_20B1);
        push(32'h0001_20B2);
        push(32'h0001_20B3);
        check("R11 full flag", {31'd0, cmd_full}, 32'd1);
        push(32'h0001_2077);
        tick(30);
        check("R9 halted while error", we_cnt, 0);
        clear_status(16'h0800);
        tick(80);
        check("R11 queued entries run", we_cnt, 4);
        check("R11 order and drop", {24'd0, we_lastb}, 32'hB3);
        check("R8 first after flush", {24'd0, we_first}, 32'hAA);
        check("R4 strobe timing final", tviol, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule